// File: doc/BRIEF.md
# Segment Address Relocation and Access Guard

This block turns a segment-relative reference into a physical address and decides in the same cycle whether the reference is allowed. It keeps a small table of segment descriptors. Each descriptor holds a physical base, a limit, a required trust level, a present flag and separate read, write and execute permissions. A request names a segment, an offset inside it, the trust level of the requester and the kind of access. The block answers with a physical address qualified by a valid flag, or with a fault and a 2-bit cause.

The physical address is the descriptor base plus the offset, so segments can be any size and can start anywhere. Trust levels run from 0, the most trusted, to 3, the least trusted. A requester may use a segment only if its level number is no larger than the level stored in the descriptor. A write port loads one descriptor per cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset every descriptor is marked absent, so any request faults with cause 0 until a descriptor is loaded.
- R2: For an accepted request, `pa` equals descriptor base plus `req_off`, taken modulo 2^32.
- R3: An offset larger than the descriptor limit faults with cause 2. An offset equal to the limit is accepted.
- R4: A request whose `req_cpl` is numerically greater than the descriptor level faults with cause 1. Equal or smaller values pass this check.
- R5: Access type encoding is 0 read, 1 write, 2 execute and 3 reserved. A read needs the read permission, a write needs write and an execute needs execute. A missing permission or type 3 faults with cause 3.
- R6: When several checks fail, the reported cause follows the priority absent (0) > level (1) > bounds (2) > type (3).
- R7: `pa_valid` and `fault` are never high together, and both are low whenever `req_valid` is low.
- R8: A descriptor write changes lookups from the next cycle on. A lookup in the cycle of the write sees the old descriptor.
- R9: A descriptor loaded with the present bit clear faults every request to it with cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load a descriptor |
| wr_idx | input | 3 | Descriptor slot to load |
| wr_base | input | 32 | Physical base to load |
| wr_limit | input | 20 | Highest legal offset to load |
| wr_dpl | input | 2 | Required trust level to load |
| wr_present | input | 1 | Present flag to load |
| wr_perm | input | 3 | Permissions {execute, write, read} |
| req_valid | input | 1 | Request present this cycle |
| req_seg | input | 3 | Segment selected by the request |
| req_off | input | 32 | Offset within the segment |
| req_cpl | input | 2 | Trust level of the requester |
| req_type | input | 2 | Access type (0 read, 1 write, 2 execute, 3 reserved) |
| pa_valid | output | 1 | Physical address valid, no fault |
| pa | output | 32 | Physical address |
| fault | output | 1 | Request rejected |
| fault_code | output | 2 | Rejection cause |

## Verification
The bench probes offsets at the limit and one past it. A design that compares with the wrong inequality would reject the last legal byte or accept the first illegal one. It also uses bases near the top of the address range, where a design that truncates or saturates the sum would give a wrong `pa`. Requests that fail several checks at once catch a wrong cause priority. Lookups made in the same cycle as a write to the same slot catch a design that forwards the new descriptor too early.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int NSEG = 8,
  parameter int AW   = 32,
  parameter int LW   = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NSEG)-1:0] wr_idx,
  input  logic [AW-1:0]           wr_base,
  input  logic [LW-1:0]           wr_limit,
  input  logic [1:0]              wr_dpl,
  input  logic                    wr_present,
  input  logic [2:0]              wr_perm,
  input  logic                    req_valid,
  input  logic [$clog2(NSEG)-1:0] req_seg,
  input  logic [AW-1:0]           req_off,
  input  logic [1:0]              req_cpl,
  input  logic [1:0]              req_type,
  output logic                    pa_valid,
  output logic [AW-1:0]           pa,
  output logic                    fault,
  output logic [1:0]              fault_code
);
  localparam int IW = $clog2(NSEG);
  localparam logic [1:0] C_ABSENT = 2'd0;
  localparam logic [1:0] C_LEVEL  = 2'd1;
  localparam logic [1:0] C_BOUND  = 2'd2;
  localparam logic [1:0] C_TYPE   = 2'd3;

  logic [AW-1:0] base_q [NSEG];
  logic [LW-1:0] lim_q  [NSEG];
  logic [1:0]    dpl_q  [NSEG];
  logic [2:0]    perm_q [NSEG];
  logic [NSEG-1:0] here_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      here_q <= '0;
      for (int i = 0; i < NSEG; i++) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
        dpl_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else if (wr_en) begin
      here_q[wr_idx] <= wr_present;
      base_q[wr_idx] <= wr_base;
      lim_q[wr_idx]  <= wr_limit;
      dpl_q[wr_idx]  <= wr_dpl;
      perm_q[wr_idx] <= wr_perm;
    end
  end

  logic [AW-1:0] s_base;
  logic [LW-1:0] s_lim;
  logic [1:0]    s_dpl;
  logic [2:0]    s_perm;
  logic          absent, lvl_bad, out_of_range, type_bad;

  assign s_base = base_q[req_seg];
  assign s_lim  = lim_q[req_seg];
  assign s_dpl  = dpl_q[req_seg];
  assign s_perm = perm_q[req_seg];

  assign absent       = !here_q[req_seg];
  assign lvl_bad      = req_cpl > s_dpl;
  assign out_of_range = req_off > {{(AW-LW){1'b0}}, s_lim};
  assign type_bad     = (req_type == 2'd3) || !s_perm[req_type];

  always_comb begin
    if (absent)            fault_code = C_ABSENT;
    else if (lvl_bad)      fault_code = C_LEVEL;
    else if (out_of_range) fault_code = C_BOUND;
    else if (type_bad)     fault_code = C_TYPE;
    else                   fault_code = C_ABSENT;
  end

  assign fault    = req_valid && (absent || lvl_bad || out_of_range || type_bad);
  assign pa_valid = req_valid && !fault;
  assign pa       = s_base + req_off;

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pa_valid && fault));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!pa_valid && !fault));
  a_r4_level_ok: assert property (@(posedge clk) disable iff (!rst_n)
    pa_valid |-> (req_cpl <= dpl_q[req_seg]));
  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pa_valid |-> (req_off <= {{(AW-LW){1'b0}}, lim_q[req_seg]}));
  a_r9_absent_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !here_q[req_seg]) |-> (fault && fault_code == C_ABSENT));
  a_r8_load_next: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_q[$past(wr_idx)] == $past(wr_base)
               && here_q[$past(wr_idx)] == $past(wr_present)));
endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n, wr_en, wr_present, req_valid;
  logic [2:0] wr_idx, req_seg, wr_perm;
  logic [31:0] wr_base, req_off;
  logic [19:0] wr_limit;
  logic [1:0] wr_dpl, req_cpl, req_type;
  logic pa_valid, fault;
  logic [31:0] pa;
  logic [1:0] fault_code;

  seg_xlate uut (.*);

  logic [31:0] m_base [8];
  logic [19:0] m_lim  [8];
  logic [1:0]  m_dpl  [8];
  logic [2:0]  m_perm [8];
  logic        m_here [8];

  int errors = 0, checks = 0;
  bit done = 0;

  function automatic logic [2:0] expect_out(input int s, input logic [31:0] off,
                                            input logic [1:0] cpl, input logic [1:0] ty);
    if (!m_here[s]) return 3'b100;
    if (cpl > m_dpl[s]) return 3'b101;
    if (off > {12'd0, m_lim[s]}) return 3'b110;
    if (ty == 2'd3 || !m_perm[s][ty]) return 3'b111;
    return 3'b000;
  endfunction

  task automatic check(input string tag);
    logic [2:0] e;
    logic [31:0] epa;
    e = expect_out(req_seg, req_off, req_cpl, req_type);
    epa = m_base[req_seg] + req_off;
    checks++;
    if (!req_valid) begin
      if (pa_valid || fault) begin
        errors++;
        $display("FAIL %s idle: pa_valid=%0b fault=%0b expected 0 0", tag, pa_valid, fault);
      end
    end else if (e[2]) begin
      if (!fault || pa_valid || fault_code != e[1:0]) begin
        errors++;
        $display("FAIL %s: fault=%0b pa_valid=%0b code=%0d expected fault code=%0d",
                 tag, fault, pa_valid, fault_code, e[1:0]);
      end
    end else if (!pa_valid || fault || pa != epa) begin
      errors++;
      $display("FAIL %s: pa_valid=%0b fault=%0b pa=%h expected valid pa=%h",
               tag, pa_valid, fault, pa, epa);
    end
  endtask

  task automatic load(input int i, input logic [31:0] b, input logic [19:0] l,
                      input logic [1:0] d, input logic p, input logic [2:0] pm);
    @(negedge clk);
    wr_en = 1; wr_idx = i[2:0]; wr_base = b; wr_limit = l; wr_dpl = d;
    wr_present = p; wr_perm = pm;
    @(posedge clk);
    m_base[i] = b; m_lim[i] = l; m_dpl[i] = d; m_here[i] = p; m_perm[i] = pm;
    #0.5 wr_en = 0;
  endtask

  task automatic ask(input int s, input logic [31:0] o, input logic [1:0] c,
                     input logic [1:0] t, input string tag);
    @(negedge clk);
    req_valid = 1; req_seg = s[2:0]; req_off = o; req_cpl = c; req_type = t;
    #1 check(tag);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5e6d));
    for (int i = 0; i < 8; i++) begin
      m_base[i] = 0; m_lim[i] = 0; m_dpl[i] = 0; m_perm[i] = 0; m_here[i] = 0;
    end
    rst_n = 0; wr_en = 0; wr_idx = 0; wr_base = 0; wr_limit = 0; wr_dpl = 0;
    wr_present = 0; wr_perm = 0; req_valid = 0; req_seg = 0; req_off = 0;
    req_cpl = 0; req_type = 0;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;

    for (int s = 0; s < 8; s++) ask(s, 0, 0, 0, "R1 reset absent");

    load(1, 32'h0001_0000, 20'h00fff, 2'd2, 1, 3'b011);
    ask(1, 32'h0000_0fff, 2, 0, "R3 offset at limit");
    ask(1, 32'h0000_1000, 2, 0, "R3 offset past limit");
    ask(1, 32'h0000_0010, 3, 1, "R4 less trusted level");
    ask(1, 32'h0000_0010, 0, 1, "R4 more trusted level");
    ask(1, 32'h0000_0010, 2, 2, "R5 execute without permission");
    ask(1, 32'h0000_0010, 2, 3, "R5 reserved type");
    ask(1, 32'h0000_2000, 3, 2, "R6 level beats bounds");
    ask(1, 32'h0000_2000, 1, 2, "R6 bounds beats type");

    load(2, 32'hffff_ff00, 20'hfffff, 2'd3, 1, 3'b111);
    ask(2, 32'h0000_0200, 3, 2, "R2 address wraps");
    load(2, 32'hffff_ff00, 20'hfffff, 2'd0, 0, 3'b111);
    ask(2, 32'h0000_0000, 3, 0, "R9 absent beats level");

    @(negedge clk);
    wr_en = 1; wr_idx = 1; wr_base = 32'h0abc_0000; wr_limit = 20'h0000f;
    wr_dpl = 3; wr_present = 1; wr_perm = 3'b100;
    req_valid = 1; req_seg = 1; req_off = 32'h10; req_cpl = 2; req_type = 0;
    #1 check("R8 same cycle sees old");
    @(posedge clk);
    m_base[1] = 32'h0abc_0000; m_lim[1] = 20'h0000f; m_dpl[1] = 3;
    m_here[1] = 1; m_perm[1] = 3'b100;
    #0.5 wr_en = 0;
    ask(1, 32'h10, 2, 0, "R8 next cycle sees new");
    ask(1, 32'h0f, 3, 2, "R8 new descriptor accepts");

    @(negedge clk); req_valid = 0; #1 check("R7 idle");

    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 3) == 0);
      wr_idx = 3'($urandom); wr_base = $urandom; wr_limit = 20'($urandom);
      wr_dpl = 2'($urandom); wr_present = ($urandom_range(0, 4) != 0);
      wr_perm = 3'($urandom);
      req_valid = ($urandom_range(0, 7) != 0);
      req_seg = 3'($urandom); req_cpl = 2'($urandom); req_type = 2'($urandom);
      case ($urandom_range(0, 3))
        0: req_off = {12'd0, m_lim[req_seg]};
        1: req_off = {12'd0, m_lim[req_seg]} + 1;
        2: req_off = 32'($urandom_range(0, 64));
        default: req_off = $urandom;
      endcase
      #1 check("R2-R9 random mix");
      @(posedge clk);
      if (wr_en) begin
        m_base[wr_idx] = wr_base; m_lim[wr_idx] = wr_limit; m_dpl[wr_idx] = wr_dpl;
        m_here[wr_idx] = wr_present; m_perm[wr_idx] = wr_perm;
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule